// File: doc/BRIEF.md
# Multiword-Block Cache Refill Controller

This block is a direct-mapped write-back data cache. It holds 256 lines, and each line holds four 32-bit words, for 1K words in total. A processor issues loads and stores on one port and sees a stall signal while its access cannot complete. A second port connects to the next memory level. That port carries a block-read command and single-word write beats, and read data comes back one word per beat.

On a miss the controller first checks the victim line. If that line is dirty, its four words go back to memory, lowest word first. The controller then requests the missing block, naming the word the processor wants. Memory returns that word first and the other three in wrapping order. The processor is released in the same cycle that its word arrives (early restart), and the rest of the line fills in the background. Each word of the filling line has an arrival flag. A later access to a word that has already arrived completes at once. Any other access waits until the line is complete.

A store that misses gets the same full-block refill. Its word replaces the first returned beat, so a line under a new tag never mixes in words from the old block.

Top module: `blk_refill_cache`

## Requirements
- R1: An address splits into a tag (bits 31:12), a line index (bits 11:4), a word select (bits 3:2) and a byte offset (bits 1:0). The byte offset has no effect on which word is read or written.
- R2: A load that hits completes with `cpu_stall` low in the cycle it is presented, and `cpu_rdata` carries the word in that cycle. A store hit writes the word with no stall and marks the line dirty.
- R3: A miss raises `mem_rd` once, holding `mem_addr` stable until `mem_ready` is seen. `mem_addr[3:2]` is the requested word and `mem_addr[1:0]` is 0. The four following `mem_rvalid` beats are taken as words w, w+1, w+2 and w+3, modulo 4.
- R4: A missing access completes in the cycle of the first `mem_rvalid` beat, while three beats are still outstanding. A load gets `mem_rdata` of that beat on `cpu_rdata`.
- R5: While a line fills, an access completes with no stall only if it targets a word of that line whose beat has already arrived. Every other access, including a hit on another line, stalls until the cycle after the last beat.
- R6: A store miss fetches the whole block. The stored value replaces the requested word, and the other three words hold the memory values.
- R7: When a dirty victim is replaced, four `mem_wr` beats write words 0, 1, 2 and 3 of the old block (old tag, same index) before `mem_rd` rises. Each beat holds its address and data until `mem_ready`. A clean or invalid victim produces no write beats.
- R8: A line becomes valid after its fourth beat. A load miss leaves the line clean, so its later eviction writes nothing. A store miss leaves it dirty.
- R9: After reset every line is invalid, `mem_rd` and `mem_wr` are low, `cpu_stall` is low with no request, and the first access misses.
- R10: Every load returns the value most recently stored to that word, or the memory's initial value if it was never stored, across any sequence of conflicting evictions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held with its operands while stalled |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid in the cycle the access completes |
| cpu_stall | output | 1 | Access cannot complete this cycle |
| mem_rd | output | 1 | Block read command, address points at the first word wanted |
| mem_wr | output | 1 | Write-back beat valid |
| mem_addr | output | 32 | Byte address of the command or beat |
| mem_wdata | output | 32 | Write-back beat data |
| mem_ready | input | 1 | Memory accepts the current command or write beat |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |

## Verification
The assertions check several rules on every cycle. They confirm that no access is granted during a fill unless its word has arrived, and that a command or write beat holds steady until it is accepted. They also confirm that no read command leaves while the victim is still dirty, that a line turns valid with all four arrival flags set after the last beat, and that a merged store leaves the line dirty. Only the bench scenarios can show the rest: the data that ends up in each word, the order and addresses of the write-back beats, the exact release cycle measured against the memory's beat timing, and end-to-end coherence across random conflicting tags.

// File: rtl/blk_refill_cache.sv
module blk_refill_cache #(
  parameter int ADDR_W  = 32,
  parameter int INDEX_W = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int LINES = 1 << INDEX_W;
  localparam int TAG_W = ADDR_W - INDEX_W - 4;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_REQ, S_FILL} st_t;

  st_t st;
  logic [DATA_W-1:0] data_q [LINES*4];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  valid_q, dirty_q;

  logic [INDEX_W-1:0] f_idx;
  logic [TAG_W-1:0]   f_tag;
  logic [1:0]         f_crit, f_cnt, wb_cnt;
  logic               f_we;
  logic [DATA_W-1:0]  f_wdata;
  logic [3:0]         arrived;

  logic [INDEX_W-1:0] c_idx;
  logic [TAG_W-1:0]   c_tag;
  logic [1:0]         c_wrd, beat_wrd;
  logic hit, fill_hit, crit_beat, grant, hit_wr, miss;
  logic unused_byte;

  assign c_idx       = cpu_addr[INDEX_W+3:4];
  assign c_wrd       = cpu_addr[3:2];
  assign c_tag       = cpu_addr[ADDR_W-1:INDEX_W+4];
  assign unused_byte = ^cpu_addr[1:0];

  assign hit       = valid_q[c_idx] && (tag_q[c_idx] == c_tag);
  assign fill_hit  = (st == S_FILL) && (c_idx == f_idx) && (c_tag == f_tag) && arrived[c_wrd];
  assign beat_wrd  = f_crit + f_cnt;
  assign crit_beat = (st == S_FILL) && mem_rvalid && (f_cnt == 2'd0);
  assign grant     = cpu_req && (((st == S_IDLE) && hit) || fill_hit || crit_beat);
  assign hit_wr    = grant && cpu_we && !crit_beat;
  assign miss      = (st == S_IDLE) && cpu_req && !hit;

  assign cpu_stall = cpu_req && !grant;
  assign cpu_rdata = crit_beat ? mem_rdata : data_q[{c_idx, c_wrd}];

  assign mem_wr    = (st == S_WB);
  assign mem_rd    = (st == S_REQ);
  assign mem_addr  = (st == S_WB) ? {tag_q[f_idx], f_idx, wb_cnt, 2'b00}
                                  : {f_tag, f_idx, f_crit, 2'b00};
  assign mem_wdata = data_q[{f_idx, wb_cnt}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      valid_q <= '0;
      dirty_q <= '0;
      f_idx   <= '0;
      f_tag   <= '0;
      f_crit  <= '0;
      f_cnt   <= '0;
      wb_cnt  <= '0;
      f_we    <= 1'b0;
      f_wdata <= '0;
      arrived <= '0;
    end else begin
      if (hit_wr) dirty_q[c_idx] <= 1'b1;
      case (st)
        S_IDLE: if (miss) begin
          f_idx   <= c_idx;
          f_tag   <= c_tag;
          f_crit  <= c_wrd;
          f_we    <= cpu_we;
          f_wdata <= cpu_wdata;
          wb_cnt  <= '0;
          st      <= (valid_q[c_idx] && dirty_q[c_idx]) ? S_WB : S_REQ;
        end
        S_WB: if (mem_ready) begin
          wb_cnt <= wb_cnt + 2'd1;
          if (wb_cnt == 2'd3) begin
            dirty_q[f_idx] <= 1'b0;
            st             <= S_REQ;
          end
        end
        S_REQ: if (mem_ready) begin
          valid_q[f_idx] <= 1'b0;
          dirty_q[f_idx] <= 1'b0;
          f_cnt          <= '0;
          arrived        <= '0;
          st             <= S_FILL;
        end
        S_FILL: if (mem_rvalid) begin
          arrived[beat_wrd] <= 1'b1;
          f_cnt             <= f_cnt + 2'd1;
          if (f_cnt == 2'd0 && f_we) dirty_q[f_idx] <= 1'b1;
          if (f_cnt == 2'd3) begin
            valid_q[f_idx] <= 1'b1;
            st             <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (hit_wr) data_q[{c_idx, c_wrd}] <= cpu_wdata;
    if (st == S_FILL && mem_rvalid)
      data_q[{f_idx, beat_wrd}] <= (f_cnt == 2'd0 && f_we) ? f_wdata : mem_rdata;
    if (st == S_REQ && mem_ready) tag_q[f_idx] <= f_tag;
  end

  AST_GRANT_ARRIVED: assert property (@(posedge clk) disable iff (!rst_n) (st == S_FILL && cpu_req && !cpu_stall && !(mem_rvalid && f_cnt == 2'd0)) |-> (c_idx == f_idx && c_tag == f_tag && arrived[c_wrd])); // R5
  AST_FILL_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n) (st == S_FILL && mem_rvalid && f_cnt == 2'd3) |=> (valid_q[$past(f_idx)] && arrived == 4'hF && st == S_IDLE)); // R8
  AST_VICTIM_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd && mem_ready) |-> !dirty_q[f_idx]); // R7
  AST_WB_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata))); // R7
  AST_RD_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr))); // R3
  AST_MERGE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n) (st == S_FILL && mem_rvalid && f_cnt == 2'd0 && f_we) |=> dirty_q[$past(f_idx)]); // R6
endmodule

// File: tb/blk_refill_cache_tb.sv
module blk_refill_cache_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic cpu_stall;
  logic mem_rd, mem_wr, mem_ready, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  blk_refill_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] back_mem [4096];
  logic [31:0] ref_mem  [4096];
  logic [31:0] wr_log   [4];
  int n_chk = 0, n_fail = 0;
  bit slow = 1'b0, done = 1'b0;
  int burst_left = 0, gap_cnt = 0;
  logic [9:0] burst_blk;
  logic [1:0] burst_w;
  int first_beat_cyc, last_beat_cyc, prior_last, rd_cmd_cyc;
  int wr_beats = 0, wr_before_rd = 0;
  logic [31:0] last_rd_addr;

  function automatic logic [31:0] seed_val(int a);
    return 32'(a) * 32'h9E37_79B1 ^ 32'hC3A5_0F1E;
  endfunction

  function automatic logic [31:0] mk(int tag, int idx, int w);
    return 32'((tag << 12) | (idx << 4) | (w << 2));
  endfunction

  function automatic logic [31:0] expect_load(logic [31:0] a);
    return ref_mem[a[13:2]];
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int dcyc, output int stalls);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; stalls = 0;
    forever begin
      #3;
      if (!cpu_stall) break;
      stalls++;
      @(negedge clk);
    end
    rd = cpu_rdata; dcyc = cyc;
    @(posedge clk); #1;
    cpu_req = 1'b0;
    if (we) ref_mem[a[13:2]] = wd;
  endtask

  initial begin
    mem_ready = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ready  = slow ? (($urandom % 2) == 0) : (($urandom % 4) != 0);
      mem_rvalid = 1'b0;
      if (burst_left > 0) begin
        if (slow) begin
          if (gap_cnt == 0) mem_rvalid = 1'b1; else gap_cnt--;
        end else if (($urandom % 3) != 0) mem_rvalid = 1'b1;
        if (mem_rvalid) mem_rdata = back_mem[{burst_blk, burst_w}];
      end
      #2;
      if (mem_rvalid) begin
        if (burst_left == 4) first_beat_cyc = cyc;
        if (burst_left == 1) last_beat_cyc = cyc;
        burst_w = burst_w + 2'd1;
        burst_left--;
        gap_cnt = 3;
      end
      if (mem_wr && mem_ready) begin
        back_mem[mem_addr[13:2]] = mem_wdata;
        if (wr_beats < 4) wr_log[wr_beats] = mem_addr;
        wr_beats++;
      end
      if (mem_rd && mem_ready) begin
        last_rd_addr = mem_addr; wr_before_rd = wr_beats;
        prior_last = last_beat_cyc; rd_cmd_cyc = cyc;
        burst_left = 4; burst_blk = mem_addr[13:4]; burst_w = mem_addr[3:2];
        gap_cnt = slow ? 3 : 0;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, v;
    int d, s, d1, seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < 4096; i++) begin back_mem[i] = seed_val(i); ref_mem[i] = seed_val(i); end
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #3;
    chk(!cpu_stall, "R9", "stall idle", 32'(cpu_stall), 0);
    chk(!mem_rd && !mem_wr, "R9", "mem idle", {30'd0, mem_rd, mem_wr}, 0);

    slow = 1'b1;
    access(1'b0, mk(1, 5, 2), 0, r, d, s);
    chk(s > 0, "R9", "first access misses", s, 1);
    chk(r == expect_load(mk(1, 5, 2)), "R4", "critical data", r, expect_load(mk(1, 5, 2)));
    chk(last_rd_addr == mk(1, 5, 2), "R3", "read cmd address", last_rd_addr, mk(1, 5, 2));
    chk(wr_before_rd == 0, "R7", "no writes for invalid victim", wr_before_rd, 0);
    chk(d == first_beat_cyc, "R4", "release cycle", d, first_beat_cyc);
    chk(burst_left == 3, "R4", "beats outstanding", burst_left, 3);
    access(1'b0, mk(1, 5, 2), 0, r, d, s);
    chk(s == 0 && burst_left > 0, "R5", "arrived word during fill", s, 0);
    access(1'b0, mk(1, 5, 1), 0, r, d, s);
    chk(d == last_beat_cyc + 1, "R5", "last word waits for fill", d, last_beat_cyc + 1);
    chk(r == expect_load(mk(1, 5, 1)), "R3", "wrap-order word", r, expect_load(mk(1, 5, 1)));
    access(1'b0, mk(1, 5, 0), 0, r, d, s);
    chk(s == 0 && r == expect_load(mk(1, 5, 0)), "R2", "load hit", r, expect_load(mk(1, 5, 0)));
    access(1'b1, mk(1, 5, 3), 32'hDEAD_0003, r, d, s);
    chk(s == 0, "R2", "store hit no stall", s, 0);
    access(1'b0, mk(1, 5, 3) | 32'd3, 0, r, d, s);
    chk(r == 32'hDEAD_0003, "R1", "byte offset ignored", r, 32'hDEAD_0003);

    wr_beats = 0;
    access(1'b0, mk(2, 5, 0), 0, r, d, s);
    chk(wr_before_rd == 4, "R7", "dirty victim beats", wr_before_rd, 4);
    for (int i = 0; i < 4; i++)
      chk(wr_log[i] == mk(1, 5, i), "R7", "write-back order", wr_log[i], mk(1, 5, i));
    chk(back_mem[mk(1, 5, 3) >> 2] == 32'hDEAD_0003, "R7", "written-back data", back_mem[mk(1, 5, 3) >> 2], 32'hDEAD_0003);
    chk(r == expect_load(mk(2, 5, 0)), "R10", "load after evict", r, expect_load(mk(2, 5, 0)));
    repeat (20) @(posedge clk);
    wr_beats = 0;
    access(1'b0, mk(3, 5, 0), 0, r, d, s);
    chk(wr_before_rd == 0, "R8", "read-filled line clean", wr_before_rd, 0);
    repeat (20) @(posedge clk);

    access(1'b1, mk(0, 9, 1), 32'h5705_E001, r, d, s);
    chk(s > 0 && d == first_beat_cyc, "R6", "store miss release", d, first_beat_cyc);
    for (int w = 0; w < 4; w++) begin
      access(1'b0, mk(0, 9, w), 0, r, d, s);
      v = (w == 1) ? 32'h5705_E001 : seed_val(mk(0, 9, w) >> 2);
      chk(r == v, "R6", "merged line word", r, v);
    end
    wr_beats = 0;
    access(1'b0, mk(1, 9, 0), 0, r, d, s);
    chk(wr_before_rd == 4, "R8", "store-miss line dirty", wr_before_rd, 4);
    chk(back_mem[mk(0, 9, 1) >> 2] == 32'h5705_E001, "R6", "merged word written back", back_mem[mk(0, 9, 1) >> 2], 32'h5705_E001);
    repeat (20) @(posedge clk);

    access(1'b0, mk(0, 20, 0), 0, r, d, s);
    access(1'b0, mk(0, 21, 0), 0, r, d, s);
    chk(rd_cmd_cyc > prior_last, "R5", "other-line miss waits", rd_cmd_cyc, prior_last + 1);
    repeat (20) @(posedge clk);
    access(1'b0, mk(0, 22, 0), 0, r, d, s);
    access(1'b0, mk(3, 5, 0), 0, r, d1, s);
    chk(s > 0 && d1 == last_beat_cyc + 1, "R5", "hit elsewhere waits", d1, last_beat_cyc + 1);
    chk(r == expect_load(mk(3, 5, 0)), "R2", "hit data after wait", r, expect_load(mk(3, 5, 0)));
    repeat (20) @(posedge clk);

    slow = 1'b0;
    for (int n = 0; n < 2500; n++) begin
      logic [31:0] a;
      logic we;
      a = mk($urandom % 4, $urandom % 8, $urandom % 4) | 32'($urandom % 4);
      we = ($urandom % 5) < 2;
      v = $urandom;
      if (we) access(1'b1, a, v, r, d, s);
      else begin
        v = expect_load(a);
        access(1'b0, a, 0, r, d, s);
        chk(r == v, "R10", "random load", r, v);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule